// File: doc/BRIEF.md
# Barrel Issue Scheduler for Hardware Thread Contexts

This block picks, on every clock, at most one hardware thread context (a stream) whose next instruction word may enter a deep execution pipeline. It announces that choice as a registered stream ID. Streams are switched on and off through activate and retire strobes. A stream that has just issued sits out until its word has left the pipeline. Arbitration among the remaining candidates uses a rotating priority, so no stream that stays eligible is passed over forever.

When the word on the issue output is a memory operation, the instruction fetch side raises `mem_op` and presents that word's lookahead value in the same cycle. The block then books a request slot for the stream, numbered by the `issue_tag` sent out with the issue. A stream may send only as many further words as its lookahead allows before it must wait for that slot's completion, which comes back as a stream ID plus tag. A stream never holds more than a fixed number of open requests. When no stream qualifies, the block raises `idle` and issues nothing.

Top module: `bis_issue_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `issue_valid` is 0 and `idle` is 1. Every stream starts inactive.
- R2: A stream issues only while it is active. `act_valid` with `act_sid` makes a stream active, and `ret_valid` with `ret_sid` makes it inactive. A retired stream does not issue again until it is reactivated.
- R3: Two issues of the same stream are at least PIPE_DEPTH (21) cycles apart. An active stream that is never blocked issues exactly every PIPE_DEPTH cycles when it is the only active stream.
- R4: At most one stream issues per cycle. The winner is the first eligible stream found by searching upward in ID order from the stream after the last winner, wrapping at NSTREAM. After reset the search begins at stream 0.
- R5: When `mem_op` is high in an issue cycle, the issuing stream opens a request whose slot number is `issue_tag`, with an allowance equal to `mem_look`. Each later issue of that stream uses one unit of allowance. A stream whose open request has no allowance left is ineligible until `done_valid` arrives with that stream's `done_sid` and that slot's `done_tag`, which closes the slot.
- R6: `issue_tag` is the lowest-numbered slot of the issuing stream that has no open request.
- R7: A stream that has MAX_OUT (8) open requests is ineligible until one of them completes.
- R8: `idle` is 1 exactly in the cycles where `issue_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Activate strobe |
| act_sid | input | SW | Stream to activate |
| ret_valid | input | 1 | Retire strobe |
| ret_sid | input | SW | Stream to retire |
| mem_op | input | 1 | The word now on the issue output is a memory operation |
| mem_look | input | 3 | Lookahead allowance of that memory word |
| done_valid | input | 1 | Memory completion strobe |
| done_sid | input | SW | Stream owning the completed request |
| done_tag | input | TAG_W | Slot of the completed request |
| issue_valid | output | 1 | A word issues this cycle |
| issue_sid | output | SW | Stream that issues |
| issue_tag | output | TAG_W | Slot booked if the issued word is a memory operation |
| idle | output | 1 | No stream was eligible |

## Verification
The issue, tag and idle outputs are registered. A selection made at one rising edge therefore appears on them during the following cycle. An activate, retire, completion or memory-word input that is present at an edge changes eligibility after that edge, so the first output it can affect comes one cycle later. The bench drives inputs at the falling edge and advances its own stream model once per rising edge, using the same order: selection from the state before the edge, then the state updates. It compares all outputs at the next falling edge. The directed spacing, blocking and ordering checks count cycles on that same falling-edge grid.

// File: rtl/bis_pkg.sv
package bis_pkg;
  // Width of the lookahead field carried by memory words
  parameter int LOOK_W = 3;
endpackage

// File: rtl/bis_rr_arb.sv
module bis_rr_arb #(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [SW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [SW-1:0] gnt_idx,
  output logic          any
);
  // Search starts just above the last winner and wraps around
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (int'(ptr) + i) % N;
      if (!any && req[k]) begin
        any     = 1'b1;
        gnt_idx = SW'(k);
        gnt[k]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bis_stream_ctx.sv
module bis_stream_ctx
  import bis_pkg::*;
#(
  parameter int PIPE_DEPTH = 21,
  parameter int MAX_OUT    = 8,
  localparam int CW    = $clog2(PIPE_DEPTH),
  localparam int TAG_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              ret,
  input  logic              grant,
  input  logic              issued,
  input  logic              mem_op,
  input  logic [LOOK_W-1:0] look,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              eligible,
  output logic [TAG_W-1:0]  free_tag
);
  logic               active;
  logic [CW-1:0]      cool;
  logic [MAX_OUT-1:0] slot_v;
  logic [LOOK_W-1:0]  slot_rem [MAX_OUT];
  logic               blocked;

  always_comb begin
    free_tag = '0;
    for (int j = MAX_OUT - 1; j >= 0; j--)
      if (!slot_v[j]) free_tag = TAG_W'(j);
    blocked = 1'b0;
    for (int j = 0; j < MAX_OUT; j++)
      if (slot_v[j] && slot_rem[j] == '0) blocked = 1'b1;
  end

  assign eligible = active && (cool == '0) && !blocked && !(&slot_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cool   <= '0;
      slot_v <= '0;
      for (int j = 0; j < MAX_OUT; j++) slot_rem[j] <= '0;
    end else begin
      if (act)      active <= 1'b1;
      else if (ret) active <= 1'b0;

      if (grant)             cool <= CW'(PIPE_DEPTH - 1);
      else if (cool != '0)   cool <= cool - 1'b1;

      for (int j = 0; j < MAX_OUT; j++) begin
        if (issued && slot_v[j] && slot_rem[j] != '0)
          slot_rem[j] <= slot_rem[j] - 1'b1;
        if (issued && mem_op && alloc_tag == TAG_W'(j)) begin
          slot_v[j]   <= 1'b1;
          slot_rem[j] <= look;
        end
        if (cmp && cmp_tag == TAG_W'(j))
          slot_v[j] <= 1'b0;
      end
    end
  end

  AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst) grant |-> active); // R2
  AST_REISSUE_GAP: assert property (@(posedge clk) disable iff (rst) grant |-> cool == '0); // R3
  AST_SLOT_CLOSE: assert property (@(posedge clk) disable iff (rst) cmp |=> !slot_v[$past(cmp_tag)]); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (issued && mem_op) |-> !(&slot_v)); // R7
endmodule

// File: rtl/bis_issue_sched.sv
module bis_issue_sched
  import bis_pkg::*;
#(
  parameter int NSTREAM    = 8,
  parameter int PIPE_DEPTH = 21,
  parameter int MAX_OUT    = 8,
  localparam int SW    = (NSTREAM > 1) ? $clog2(NSTREAM) : 1,
  localparam int TAG_W = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_valid,
  input  logic [SW-1:0]     act_sid,
  input  logic              ret_valid,
  input  logic [SW-1:0]     ret_sid,
  input  logic              mem_op,
  input  logic [LOOK_W-1:0] mem_look,
  input  logic              done_valid,
  input  logic [SW-1:0]     done_sid,
  input  logic [TAG_W-1:0]  done_tag,
  output logic              issue_valid,
  output logic [SW-1:0]     issue_sid,
  output logic [TAG_W-1:0]  issue_tag,
  output logic              idle
);
  logic [NSTREAM-1:0] elig;
  logic [NSTREAM-1:0] gnt;
  logic [NSTREAM-1:0] grant_vec;
  logic [SW-1:0]      gnt_idx;
  logic               any;
  logic [SW-1:0]      ptr;
  logic [TAG_W-1:0]   ftag [NSTREAM];

  bis_rr_arb #(.N(NSTREAM), .SW(SW)) u_arb (
    .req(elig), .ptr(ptr), .gnt(gnt), .gnt_idx(gnt_idx), .any(any)
  );

  assign grant_vec = gnt & {NSTREAM{any}};

  for (genvar g = 0; g < NSTREAM; g++) begin : g_ctx
    bis_stream_ctx #(.PIPE_DEPTH(PIPE_DEPTH), .MAX_OUT(MAX_OUT)) u_ctx (
      .clk      (clk),
      .rst      (rst),
      .act      (act_valid && act_sid == SW'(g)),
      .ret      (ret_valid && ret_sid == SW'(g)),
      .grant    (grant_vec[g]),
      .issued   (issue_valid && issue_sid == SW'(g)),
      .mem_op   (mem_op),
      .look     (mem_look),
      .alloc_tag(issue_tag),
      .cmp      (done_valid && done_sid == SW'(g)),
      .cmp_tag  (done_tag),
      .eligible (elig[g]),
      .free_tag (ftag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_sid   <= '0;
      issue_tag   <= '0;
      idle        <= 1'b1;
      ptr         <= SW'(NSTREAM - 1);
    end else begin
      issue_valid <= any;
      issue_sid   <= gnt_idx;
      issue_tag   <= ftag[gnt_idx];
      idle        <= !any;
      if (any) ptr <= gnt_idx;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_vec)); // R4
  AST_IDLE_SEEN: assert property (@(posedge clk) disable iff (rst) (elig == '0) |=> idle); // R8
endmodule

// File: tb/sim_bis_issue_sched.sv
`timescale 1ns/1ps
module sim_bis_issue_sched;
  localparam int N = 8;
  localparam int D = 21;
  localparam int M = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic act_valid = 0, ret_valid = 0, mem_op = 0, done_valid = 0;
  logic [2:0] act_sid = 0, ret_sid = 0, done_sid = 0, done_tag = 0, mem_look = 0;
  logic issue_valid, idle;
  logic [2:0] issue_sid, issue_tag;

  always #4 clk = ~clk;

  bis_issue_sched #(.NSTREAM(N), .PIPE_DEPTH(D), .MAX_OUT(M)) u0 (
    .clk(clk), .rst(rst),
    .act_valid(act_valid), .act_sid(act_sid),
    .ret_valid(ret_valid), .ret_sid(ret_sid),
    .mem_op(mem_op), .mem_look(mem_look),
    .done_valid(done_valid), .done_sid(done_sid), .done_tag(done_tag),
    .issue_valid(issue_valid), .issue_sid(issue_sid), .issue_tag(issue_tag), .idle(idle)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  // stimulus for the next edge
  bit d_act, d_ret, d_mem, d_cmp;
  int d_act_id, d_ret_id, d_look, d_cmp_sid, d_cmp_tag;

  // reference model
  bit m_act [N];
  int m_cool [N];
  bit m_v [N][M];
  int m_rem [N][M];
  int m_ptr;
  bit e_valid, e_idle;
  int e_sid, e_tag;

  int last_iss [N];
  int last_gap;
  bit new_issue;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit m_elig(input int s);
    bit blk, full;
    blk = 0; full = 1;
    for (int j = 0; j < M; j++) begin
      if (m_v[s][j] && m_rem[s][j] == 0) blk = 1;
      if (!m_v[s][j]) full = 0;
    end
    return m_act[s] && m_cool[s] == 0 && !blk && !full;
  endfunction

  function automatic int m_free(input int s);
    for (int j = 0; j < M; j++) if (!m_v[s][j]) return j;
    return 0;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      m_act[s] = 0; m_cool[s] = 0; last_iss[s] = -1;
      for (int j = 0; j < M; j++) begin m_v[s][j] = 0; m_rem[s][j] = 0; end
    end
    m_ptr = N - 1;
    e_valid = 0; e_sid = 0; e_tag = 0; e_idle = 1;
  endtask

  task automatic model_step();
    bit cv, found;
    int cs, ct, g, gt;
    cv = e_valid; cs = e_sid; ct = e_tag;
    found = 0; g = 0; gt = 0;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (m_ptr + i) % N;
      if (!found && m_elig(k)) begin found = 1; g = k; end
    end
    if (found) gt = m_free(g);
    for (int s = 0; s < N; s++) begin
      if (found && s == g) m_cool[s] = D - 1;
      else if (m_cool[s] > 0) m_cool[s]--;
      if (d_act && d_act_id == s) m_act[s] = 1;
      else if (d_ret && d_ret_id == s) m_act[s] = 0;
    end
    if (cv) begin
      for (int j = 0; j < M; j++)
        if (m_v[cs][j] && m_rem[cs][j] > 0) m_rem[cs][j]--;
      if (d_mem) begin m_v[cs][ct] = 1; m_rem[cs][ct] = d_look; end
    end
    if (d_cmp) m_v[d_cmp_sid][d_cmp_tag] = 0;
    e_valid = found; e_idle = !found;
    if (found) begin e_sid = g; e_tag = gt; m_ptr = g; end
  endtask

  task automatic step();
    act_valid = d_act; act_sid = 3'(d_act_id);
    ret_valid = d_ret; ret_sid = 3'(d_ret_id);
    mem_op = d_mem; mem_look = 3'(d_look);
    done_valid = d_cmp; done_sid = 3'(d_cmp_sid); done_tag = 3'(d_cmp_tag);
    model_step();
    d_act = 0; d_ret = 0; d_mem = 0; d_cmp = 0;
    @(negedge clk);
    cyc++;
    chk(issue_valid == e_valid, "R4 issue_valid", int'(issue_valid), int'(e_valid));
    if (e_valid && issue_valid) begin
      chk(int'(issue_sid) == e_sid, "R4 issue_sid", int'(issue_sid), e_sid);
      chk(int'(issue_tag) == e_tag, "R6 issue_tag", int'(issue_tag), e_tag);
    end
    chk(idle == e_idle, "R8 idle", int'(idle), int'(e_idle));
    new_issue = issue_valid;
    last_gap = -1;
    if (issue_valid) begin
      if (last_iss[issue_sid] >= 0) begin
        last_gap = cyc - last_iss[issue_sid];
        chk(last_gap >= D, "R3 reissue gap", last_gap, D);
      end
      last_iss[issue_sid] = cyc;
    end
  endtask

  task automatic clean_stream(input int s);
    for (int j = 0; j < M; j++) begin
      if (m_v[s][j]) begin
        d_cmp = 1; d_cmp_sid = s; d_cmp_tag = j;
        step();
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    int prev;
    void'($urandom(32'd20240611));
    d_act = 0; d_ret = 0; d_mem = 0; d_cmp = 0;
    d_act_id = 0; d_ret_id = 0; d_look = 0; d_cmp_sid = 0; d_cmp_tag = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(issue_valid == 0, "R1 valid in reset", int'(issue_valid), 0);
    chk(idle == 1, "R1 idle in reset", int'(idle), 1);
    rst = 1'b0;
    // R1 and R2: nothing active, nothing issues
    cnt = 0;
    for (int i = 0; i < 5; i++) begin step(); if (issue_valid) cnt++; end
    chk(cnt == 0, "R1 R2 no issue before activation", cnt, 0);

    // R3: single stream issues exactly every PIPE_DEPTH cycles
    d_act = 1; d_act_id = 0;
    for (int i = 0; i < 80; i++) begin
      step();
      if (new_issue && last_gap >= 0) chk(last_gap == D, "R3 exact spacing", last_gap, D);
    end

    // R2: retire stops issue
    d_ret = 1; d_ret_id = 0;
    step(); step();
    cnt = 0;
    for (int i = 0; i < 45; i++) begin step(); if (issue_valid) cnt++; end
    chk(cnt == 0, "R2 retired stream silent", cnt, 0);

    // R5: memory word with lookahead 1 allows one more word, then blocks
    d_act = 1; d_act_id = 0;
    for (int i = 0; i < 40 && !e_valid; i++) step();
    d_mem = 1; d_look = 1;
    step();
    cnt = 0;
    for (int i = 0; i < 80; i++) begin step(); if (issue_valid) cnt++; end
    chk(cnt == 1, "R5 words after lookahead 1", cnt, 1);
    d_cmp = 1; d_cmp_sid = 0; d_cmp_tag = 0;
    step();
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); if (issue_valid) cnt++; end
    chk(cnt >= 1, "R5 resumes after completion", cnt, 1);

    // R7 and R6: eight open requests block; completion frees slot 0
    cnt = 0;
    for (int i = 0; i < 400 && cnt < M; i++) begin
      if (e_valid) begin d_mem = 1; d_look = 7; cnt++; end
      step();
    end
    cnt = 0;
    for (int i = 0; i < 50; i++) begin step(); if (issue_valid) cnt++; end
    chk(cnt == 0, "R7 stream with eight open requests", cnt, 0);
    d_cmp = 1; d_cmp_sid = 0; d_cmp_tag = 0;
    step();
    for (int i = 0; i < 40 && !issue_valid; i++) step();
    chk(issue_valid == 1, "R7 resumes after one completion", int'(issue_valid), 1);
    chk(issue_tag == 0, "R6 lowest free slot", int'(issue_tag), 0);
    step();
    clean_stream(0);

    // R4: rotating order among streams 1..7
    d_ret = 1; d_ret_id = 0;
    step();
    repeat (25) step();
    for (int s = 1; s < N; s++) begin d_act = 1; d_act_id = s; step(); end
    prev = -1;
    for (int i = 0; i < 120; i++) begin
      step();
      if (issue_valid) begin
        if (prev >= 0) begin
          int want;
          want = (prev == N - 1) ? 1 : prev + 1;
          chk(int'(issue_sid) == want, "R4 rotation order", int'(issue_sid), want);
        end
        prev = int'(issue_sid);
      end
    end

    // Random mix of all behaviours
    d_act = 1; d_act_id = 0;
    step();
    for (int i = 0; i < 2500; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) begin d_act = 1; d_act_id = $urandom % N; end
      else if (r < 4) begin d_ret = 1; d_ret_id = $urandom % N; end
      if (e_valid && ($urandom % 10) < 4) begin d_mem = 1; d_look = $urandom % 8; end
      if (($urandom % 5) != 0) begin
        int s, st;
        bit got;
        s = $urandom % N; st = $urandom % M; got = 0;
        for (int j = 0; j < M; j++) begin
          int t;
          t = (st + j) % M;
          if (!got && m_v[s][t]) begin
            got = 1; d_cmp = 1; d_cmp_sid = s; d_cmp_tag = t;
          end
        end
      end
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule